// File: doc/BRIEF.md
# Non-Maskable Interrupt Edge Monitor

This block watches a single asynchronous non-maskable interrupt pad. It brings the pad into the clock domain, looks for transitions of the polarity that software has chosen, and records each qualifying transition in a pending flag. Software clears that flag by writing a one to it.

An overrun flag shows that software missed an event. Whenever a new qualifying transition arrives, the overrun flag is reloaded with the value the pending flag held just before that transition. It is therefore set only when the previous event had not yet been cleared.

Software reaches the block through a 32-bit register port with two words. The status word is at offset 0x0 and the configuration word is at offset 0x4. The interrupt request is raised while either flag is set and at least one polarity is enabled.

Top module: `nmi_edge_monitor`

## Requirements
- R1: After reset the status word, the configuration word and `irq_o` all read 0.
- R2: With the rise enable set (configuration bit 0), a low-to-high pad change sets the pending flag (status bit 31). The flag is readable after the third rising clock edge that follows the pad change.
- R3: With the fall enable set (configuration bit 1), a high-to-low pad change sets the pending flag with the same latency as in R2.
- R4: With both enables set, every pad transition counts as an event. With neither enable set, no transition changes the status word.
- R5: Writing 1 to status bit 31 clears the pending flag, and writing 1 to status bit 30 clears the overrun flag. Writing 0 to either bit leaves it unchanged.
- R6: On every qualifying event the overrun flag (status bit 30) takes the pending flag's value from just before the event. This sets the overrun flag if an event was still pending and clears it if none was pending.
- R7: When an event and a clearing write hit the same cycle, the event wins. The pending flag ends set, and the overrun flag takes the pending value from before that cycle.
- R8: `irq_o` is 1 exactly when the pending flag or the overrun flag is set and at least one enable bit is set.
- R9: Status bits 29..0 and configuration bits 31..2 read as 0 and ignore writes. Any other offset reads as 0.
- R10: The configuration word reads back the enable bits last written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pad_i | input | 1 | Asynchronous interrupt pad |
| addr_i | input | ADDR_W | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the addressed word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed word (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to create from the ports is a clearing write that lands in exactly the same clock cycle as a detected edge. That cycle sits behind the synchronizer delay. The stimulus changes the pad and waits two clock edges, then holds the write strobe across the edge at which the event registers. The overrun rule that clears the flag is also hard to reach. The stimulus first builds up both flags, clears only the pending flag, and then sends another edge so that the overrun flag must drop.

// File: rtl/nmi_edge_monitor.sv
module nmi_edge_monitor #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CFG_OFS  = ADDR_W'(4);
  localparam int PEND_BIT = 31;
  localparam int OVF_BIT  = 30;

  logic [SYNC_STAGES:0] sync_q;
  logic pend_q, ovf_q, rise_en_q, fall_en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], pad_i};

  wire cur  = sync_q[SYNC_STAGES-1];
  wire prev = sync_q[SYNC_STAGES];
  wire evt  = (rise_en_q & cur & ~prev) | (fall_en_q & ~cur & prev);

  wire stat_wr = wr_en_i && addr_i == STAT_OFS;
  wire cfg_wr  = wr_en_i && addr_i == CFG_OFS;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q    <= 1'b0;
      ovf_q     <= 1'b0;
      rise_en_q <= 1'b0;
      fall_en_q <= 1'b0;
    end else begin
      if (evt) begin
        pend_q <= 1'b1;
        ovf_q  <= pend_q;
      end else begin
        if (stat_wr && wdata_i[PEND_BIT]) pend_q <= 1'b0;
        if (stat_wr && wdata_i[OVF_BIT])  ovf_q  <= 1'b0;
      end
      if (cfg_wr) begin
        rise_en_q <= wdata_i[0];
        fall_en_q <= wdata_i[1];
      end
    end

  always_comb begin
    rdata_o = '0;
    if (addr_i == STAT_OFS) begin
      rdata_o[PEND_BIT] = pend_q;
      rdata_o[OVF_BIT]  = ovf_q;
    end else if (addr_i == CFG_OFS) begin
      rdata_o[0] = rise_en_q;
      rdata_o[1] = fall_en_q;
    end
  end

  assign irq_o = (pend_q | ovf_q) & (rise_en_q | fall_en_q);

  logic unused_wdata;
  assign unused_wdata = &{1'b0, wdata_i[29:2]};
endmodule

// File: rtl/nmi_edge_monitor_chk.sv
module nmi_edge_monitor_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              wd_pend,
  input logic [31:0]       rdata_o,
  input logic              irq_o,
  input logic              pend,
  input logic              ovf,
  input logic              ren,
  input logic              fen
);
  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ren || fen));

  // R5
  pend_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend) |-> $past(wr_en_i && addr_i == '0 && wd_pend));

  // R6
  ovf_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(pend));

  // R4
  no_event_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ren || fen) |=> !$rose(pend));

  // R9
  stat_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == '0) |-> (rdata_o[29:0] == '0));
endmodule

bind nmi_edge_monitor nmi_edge_monitor_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .wd_pend(wdata_i[31]), .rdata_o(rdata_o), .irq_o(irq_o),
  .pend(pend_q), .ovf(ovf_q), .ren(rise_en_q), .fen(fall_en_q));

// File: tb/nmi_edge_monitor_tb_top.sv
`timescale 1ns/1ps
module nmi_edge_monitor_tb_top;
  logic clk = 0, rst_n = 0, pad = 0, wr_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  bit m_pend = 0, m_ovf = 0, m_ren = 0, m_fen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nmi_edge_monitor dut_i (.clk(clk), .rst_n(rst_n), .pad_i(pad), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = 0; #1;
  endtask

  task automatic check_state(string r);
    logic [31:0] d;
    rd(8'h0, d);
    chk(r, d, {m_pend, m_ovf, 30'b0});
    chk({r, "/R8 irq"}, {31'b0, irq}, {31'b0, (m_pend | m_ovf) & (m_ren | m_fen)});
  endtask

  task automatic model_edge(bit v);
    if ((v && m_ren) || (!v && m_fen)) begin
      m_ovf = m_pend;
      m_pend = 1;
    end
  endtask

  task automatic toggle(bit v);
    @(negedge clk); pad = v;
    repeat (3) @(negedge clk);
    model_edge(v);
  endtask

  task automatic set_cfg(bit re, bit fe);
    wr(8'h4, {30'b0, fe, re});
    m_ren = re; m_fen = fe;
  endtask

  task automatic clear_all();
    wr(8'h0, 32'hC000_0000);
    m_pend = 0; m_ovf = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h0, d); chk("R1 status", d, 0);
    rd(8'h4, d); chk("R1 config", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    for (int cfg = 0; cfg < 4; cfg++) begin
      string tag;
      tag = (cfg == 1) ? "R2" : (cfg == 2) ? "R3" : "R4";
      set_cfg(cfg[0], cfg[1]);
      rd(8'h4, d); chk("R10 cfg readback", d, cfg);
      clear_all();
      for (int i = 0; i < 4; i++) begin
        toggle(~pad);
        check_state({tag, "/R6 sweep"});
      end
      clear_all();
      check_state("R5 clear both");
    end

    set_cfg(1, 1);
    toggle(1); toggle(0);
    check_state("R6 overrun set");
    wr(8'h0, 32'h0);
    check_state("R5 write zero");
    wr(8'h0, 32'h4000_0000); m_ovf = 0;
    check_state("R5 clear ovf only");
    toggle(1);
    wr(8'h0, 32'h8000_0000); m_pend = 0;
    check_state("R5 clear pend only");
    toggle(0);
    check_state("R6 overrun cleared by event");

    toggle(1); toggle(0);
    wr(8'h0, 32'h8000_0000); m_pend = 0;
    toggle(1);
    check_state("R6 pend set ovf dropped");
    @(negedge clk); pad = 0;
    @(negedge clk);
    @(negedge clk); addr = 0; wdata = 32'hC000_0000; wr_en = 1;
    @(negedge clk); wr_en = 0;
    m_ovf = m_pend; m_pend = 1;
    check_state("R7 set wins");

    set_cfg(0, 0);
    check_state("R8 irq masked");
    wr(8'h0, 32'h3FFF_FFFF);
    rd(8'h0, d); chk("R9 status reserved", d, {m_pend, m_ovf, 30'b0});
    wr(8'h4, 32'hFFFF_FFFC);
    rd(8'h4, d); chk("R9 cfg reserved", d, 0);
    rd(8'h8, d); chk("R9 unmapped", d, 0);
    toggle(1); toggle(0);
    check_state("R4 disabled no event");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule